// File: doc/BRIEF.md
# Single-Bit Operation Unit with Carry Accumulator

This unit carries out the single-bit instructions of a small 8-bit controller core. An operation starts with an 8-bit bit address and a 4-bit operation code. The unit turns the bit address into a byte address and a bit index, and it fetches that byte over a simple byte-wide memory port. It then tests or changes the one bit it selected. When the bit changes, the whole byte goes back to memory, so the other seven bits keep their values. A one-bit carry register acts as the accumulator for loads, stores and boolean combinations, including the forms that use the inverted operand.

Two windows share the bit-address space. The lower half covers sixteen packed RAM bytes. The upper half reaches only registers whose byte address is a multiple of eight. The carry bit is also visible in the upper half, at bit address 0xD7 (bit 7 of the status byte 0xD0). That address is served straight from the internal carry register and never touches memory. The core pulses `start` for one cycle and waits for the one-cycle `done`. Starts that arrive before `done` are dropped.

Top module: `bitop_unit`

## Requirements
- R1: A bit address 0x00–0x7F selects byte 0x20 + (address >> 3), bit address[2:0]. For example, 0x1A selects byte 0x23, bit 2.
- R2: A bit address 0x80–0xFF selects byte (address & 0xF8), bit address[2:0]. The one exception is 0xD7 (see R7).
- R3: Carry operations on a memory bit b: code 0 sets C = b; code 2 sets C = C & b; code 3 sets C = C & ~b; code 4 sets C = C | b; code 5 sets C = C | ~b. None of these write memory.
- R4: Bit-write operations: code 1 sets b = C, code 6 clears b, code 7 sets b, code 8 inverts b. Each one writes the whole byte back, and the seven unselected bits keep the values that were read.
- R5: Code 9 clears C, code 10 sets C and code 11 inverts C. None of them accesses memory.
- R6: Code 12 (test-and-clear) drives `test_hit` with the old value of the bit while `done` is high. The byte is written back with that bit cleared only if the bit was 1. Every other code drives `test_hit` low.
- R7: Bit address 0xD7 is the carry register itself. Every bit operation on it reads and updates C with no memory access. Memory byte 0xD0 stays unchanged.
- R8: Latency is counted from the cycle in which `start` is high to the cycle in which `done` is high:
  - 4 cycles when a write-back occurs;
  - 3 cycles for a memory read with no write;
  - 2 cycles when there is no memory access.
  
  `mem_rdata` is sampled one cycle after `mem_rd`. `done` lasts one cycle and follows the write cycle directly.
- R9: A `start` that arrives while an operation is still in progress, before `done`, is ignored.
- R10: After reset, C is 0, and `done`, `mem_rd` and `mem_we` are low.
- R11: Codes 13–15 change nothing and complete in 2 cycles with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 4 | Operation code (R3–R6, R11) |
| bit_addr | input | 8 | Bit address |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Carry accumulator |
| test_hit | output | 1 | Old bit value from test-and-clear, valid with done |
| mem_addr | output | 8 | Byte address to memory |
| mem_rd | output | 1 | Read strobe; data expected the next cycle |
| mem_rdata | input | 8 | Read data |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |

## Verification
The hardest case to reach from the ports is the carry alias at 0xD7. There, a bit operation must give the same result as the matching carry operation without any memory traffic. The stimulus gets there by first setting carry to a known value through ordinary loads. It then applies set, invert, inverted-OR and test-and-clear to 0xD7. After each one it checks the carry value, the 2-cycle latency and the untouched byte 0xD0. Two more cases are exercised: a second start issued while a write is still pending, and test-and-clear on a bit that is already 0, which must not write.

// File: rtl/bitop_pkg.sv
// Package: shared operation codes, sequencer states and the helper that
// tells whether an operation needs a memory bit operand.
package bitop_pkg;

    typedef enum logic [3:0] {
        OP_LDC    = 4'd0,
        OP_STC    = 4'd1,
        OP_ANDC   = 4'd2,
        OP_ANDNC  = 4'd3,
        OP_ORC    = 4'd4,
        OP_ORNC   = 4'd5,
        OP_CLRB   = 4'd6,
        OP_SETB   = 4'd7,
        OP_CPLB   = 4'd8,
        OP_CLRC   = 4'd9,
        OP_SETC   = 4'd10,
        OP_CPLC   = 4'd11,
        OP_TSTCLR = 4'd12
    } bitop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_EVAL,
        ST_WR,
        ST_LOCAL,
        ST_DONE
    } seq_e;

    // True when the operation reads or writes an addressed bit
    function automatic logic op_uses_bit(input bitop_e o);
        return (o <= OP_CPLB) || (o == OP_TSTCLR);
    endfunction

endpackage

// File: rtl/bitop_addr_map.sv
// Address map: turns a bit address into a byte address and a bit index.
// The lower half maps to a packed RAM window at RAM_BASE. The upper half
// maps to registers whose byte address is a multiple of the byte width.
// Assumes BYTE_W is a power of two.
module bitop_addr_map #(
    parameter int              BYTE_W     = 8,
    parameter logic [7:0]      RAM_BASE   = 8'h20,
    parameter logic [7:0]      CARRY_BYTE = 8'hD0,
    parameter int              CARRY_IDX  = 7,
    localparam int             IDX_W      = $clog2(BYTE_W)
) (
    input  logic [BYTE_W-1:0]  bit_addr,
    output logic [BYTE_W-1:0]  byte_addr,
    output logic [IDX_W-1:0]   bit_idx,
    output logic               is_carry
);
    logic upper;

    // Select the window and compute the byte, index and carry alias
    always_comb begin
        upper     = bit_addr[BYTE_W-1];
        bit_idx   = bit_addr[IDX_W-1:0];
        byte_addr = upper ? {bit_addr[BYTE_W-1:IDX_W], {IDX_W{1'b0}}}
                          : RAM_BASE + (bit_addr >> IDX_W);
        is_carry  = upper && (byte_addr == CARRY_BYTE)
                          && (bit_idx == IDX_W'(CARRY_IDX));
    end
endmodule

// File: rtl/bitop_alu.sv
// Bit logic: computes the next carry, the new bit value, whether the
// bit must be written back, and the test-and-clear hit. Pure combinational.
module bitop_alu
    import bitop_pkg::*;
(
    input  bitop_e op,
    input  logic   cin,
    input  logic   bval,
    output logic   cout,
    output logic   bnew,
    output logic   bwr,
    output logic   hit
);
    // Decode the operation into its carry and bit effects
    always_comb begin
        cout = cin;
        bnew = bval;
        bwr  = 1'b0;
        hit  = 1'b0;
        unique case (op)
            OP_LDC:    cout = bval;
            OP_STC:    begin bnew = cin;   bwr = 1'b1; end
            OP_ANDC:   cout = cin & bval;
            OP_ANDNC:  cout = cin & ~bval;
            OP_ORC:    cout = cin | bval;
            OP_ORNC:   cout = cin | ~bval;
            OP_CLRB:   begin bnew = 1'b0;  bwr = 1'b1; end
            OP_SETB:   begin bnew = 1'b1;  bwr = 1'b1; end
            OP_CPLB:   begin bnew = ~bval; bwr = 1'b1; end
            OP_CLRC:   cout = 1'b0;
            OP_SETC:   cout = 1'b1;
            OP_CPLC:   cout = ~cin;
            OP_TSTCLR: begin hit = bval; bnew = 1'b0; bwr = bval; end
            default:   cout = cin;
        endcase
    end
endmodule

// File: rtl/bitop_merge.sv
// Byte merge: replaces one bit of a read byte and passes the rest through.
module bitop_merge #(
    parameter int  BYTE_W = 8,
    localparam int IDX_W  = $clog2(BYTE_W)
) (
    input  logic [BYTE_W-1:0] rdata,
    input  logic [IDX_W-1:0]  idx,
    input  logic              bnew,
    output logic [BYTE_W-1:0] wdata
);
    // One mux per bit lane
    for (genvar g = 0; g < BYTE_W; g++) begin : g_lane
        assign wdata[g] = (idx == IDX_W'(g)) ? bnew : rdata[g];
    end
endmodule

// File: rtl/bitop_unit.sv
// Top: sequences one bit operation at a time over a byte-wide memory port
// and holds the carry accumulator. Memory returns read data one cycle after
// mem_rd, and a write completes at the edge that ends the mem_we cycle.
// A start is taken only in the idle state.
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int         BYTE_W     = 8,
    parameter logic [7:0] RAM_BASE   = 8'h20,
    parameter logic [7:0] CARRY_BYTE = 8'hD0,
    parameter int         CARRY_IDX  = 7,
    localparam int        IDX_W      = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [BYTE_W-1:0] bit_addr,
    output logic              done,
    output logic              carry,
    output logic              test_hit,
    output logic [BYTE_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata
);
    seq_e              st;
    bitop_e            op_q;
    logic [BYTE_W-1:0] addr_q, wdata_q, rkeep_q;
    logic [IDX_W-1:0]  idx_q;
    logic              carry_q, hit_q;

    logic [BYTE_W-1:0] map_byte, merged;
    logic [IDX_W-1:0]  map_idx;
    logic              map_carry;
    logic              alu_bval, alu_cout, alu_bnew, alu_bwr, alu_hit;

    bitop_addr_map #(
        .BYTE_W(BYTE_W), .RAM_BASE(RAM_BASE),
        .CARRY_BYTE(CARRY_BYTE), .CARRY_IDX(CARRY_IDX)
    ) u_map (
        .bit_addr(bit_addr), .byte_addr(map_byte),
        .bit_idx(map_idx), .is_carry(map_carry)
    );

    // Operand: the carry itself on the local path, else the fetched bit
    assign alu_bval = (st == ST_LOCAL) ? carry_q : mem_rdata[idx_q];

    bitop_alu u_alu (
        .op(op_q), .cin(carry_q), .bval(alu_bval),
        .cout(alu_cout), .bnew(alu_bnew), .bwr(alu_bwr), .hit(alu_hit)
    );

    bitop_merge #(.BYTE_W(BYTE_W)) u_merge (
        .rdata(mem_rdata), .idx(idx_q), .bnew(alu_bnew), .wdata(merged)
    );

    // Sequencer: accept, fetch, evaluate, write back, report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            op_q    <= OP_LDC;
            addr_q  <= '0;
            idx_q   <= '0;
            wdata_q <= '0;
            rkeep_q <= '0;
            carry_q <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    op_q   <= bitop_e'(op);
                    addr_q <= map_byte;
                    idx_q  <= map_idx;
                    st     <= (op_uses_bit(bitop_e'(op)) && !map_carry)
                              ? ST_RD : ST_LOCAL;
                end
                ST_RD:   st <= ST_EVAL;
                ST_EVAL: begin
                    carry_q <= alu_cout;
                    hit_q   <= alu_hit;
                    wdata_q <= merged;
                    rkeep_q <= mem_rdata;
                    st      <= alu_bwr ? ST_WR : ST_DONE;
                end
                ST_WR:   st <= ST_DONE;
                ST_LOCAL: begin
                    carry_q <= alu_bwr ? alu_bnew : alu_cout;
                    hit_q   <= alu_hit;
                    st      <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Drive the outputs straight from state
    assign done      = (st == ST_DONE);
    assign mem_rd    = (st == ST_RD);
    assign mem_we    = (st == ST_WR);
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign carry     = carry_q;
    assign test_hit  = hit_q;

    // R8
    wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> done);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));
    // R4
    keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (((mem_wdata ^ rkeep_q) & ~(BYTE_W'(1) << idx_q)) == '0));
    // R3
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st inside {ST_IDLE, ST_RD, ST_WR, ST_DONE}) |=> $stable(carry));
    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(addr_q));
endmodule

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0] op;
        logic [7:0] addr;
        logic       c;
        logic [7:0] baddr;
        logic [7:0] bval;
        logic       hit;
        logic [2:0] lat;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  8'h1A, 1'b1, 8'h23, 8'h04, 1'b0, 3'd3},
        '{4'd1,  8'h00, 1'b1, 8'h20, 8'h01, 1'b0, 3'd4},
        '{4'd3,  8'h1A, 1'b0, 8'h23, 8'h04, 1'b0, 3'd3},
        '{4'd5,  8'h01, 1'b1, 8'h20, 8'h01, 1'b0, 3'd3},
        '{4'd2,  8'h01, 1'b0, 8'h20, 8'h01, 1'b0, 3'd3},
        '{4'd4,  8'h7F, 1'b1, 8'h2F, 8'h80, 1'b0, 3'd3},
        '{4'd6,  8'h7F, 1'b1, 8'h2F, 8'h00, 1'b0, 3'd4},
        '{4'd7,  8'h93, 1'b1, 8'h90, 8'hAD, 1'b0, 3'd4},
        '{4'd8,  8'h90, 1'b1, 8'h90, 8'hAC, 1'b0, 3'd4},
        '{4'd9,  8'h00, 1'b0, 8'h20, 8'h01, 1'b0, 3'd2},
        '{4'd0,  8'h97, 1'b1, 8'h90, 8'hAC, 1'b0, 3'd3},
        '{4'd11, 8'h00, 1'b0, 8'h20, 8'h01, 1'b0, 3'd2},
        '{4'd10, 8'h00, 1'b1, 8'h20, 8'h01, 1'b0, 3'd2},
        '{4'd12, 8'h1A, 1'b1, 8'h23, 8'h00, 1'b1, 3'd4},
        '{4'd12, 8'h1A, 1'b1, 8'h23, 8'h00, 1'b0, 3'd3},
        '{4'd2,  8'h7F, 1'b0, 8'h2F, 8'h00, 1'b0, 3'd3},
        '{4'd7,  8'hD7, 1'b1, 8'hD0, 8'h00, 1'b0, 3'd2},
        '{4'd8,  8'hD7, 1'b0, 8'hD0, 8'h00, 1'b0, 3'd2},
        '{4'd5,  8'hD7, 1'b1, 8'hD0, 8'h00, 1'b0, 3'd2},
        '{4'd12, 8'hD7, 1'b0, 8'hD0, 8'h00, 1'b1, 3'd2},
        '{4'd1,  8'hF8, 1'b0, 8'hF8, 8'hFE, 1'b0, 3'd4},
        '{4'd0,  8'hFF, 1'b1, 8'hF8, 8'hFE, 1'b0, 3'd3},
        '{4'd15, 8'h00, 1'b1, 8'h20, 8'h01, 1'b0, 3'd2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] bit_addr = '0;
    logic       done, carry, test_hit, mem_rd, mem_we;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata;
    logic [7:0] mem [256];
    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitop_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_addr(bit_addr),
        .done(done), .carry(carry), .test_hit(test_hit),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    // Memory model with a preload applied during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
            mem[8'h23] <= 8'h04;
            mem[8'h2F] <= 8'h80;
            mem[8'h90] <= 8'hA5;
            mem[8'hF8] <= 8'hFF;
            mem_rdata  <= 8'h00;
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr];
            if (mem_we) mem[mem_addr] <= mem_wdata;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] o, input logic [7:0] a);
        if (o >= 4'd13) return "R11";
        if (o >= 4'd9 && o <= 4'd11) return "R5";
        if (a == 8'hD7) return "R7";
        if (o == 4'd12) return "R6";
        if (o == 4'd1 || (o >= 4'd6 && o <= 4'd8)) return "R4";
        return "R3";
    endfunction

    // Issue one operation and return the cycles until done
    task automatic run_op(input logic [3:0] o, input logic [7:0] a, output int lat);
        @(negedge clk);
        start = 1'b1; op = o; bit_addr = a;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int lat;
        int seen;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(carry == 1'b0, "R10", "carry", carry, 0);
        chk(!done && !mem_rd && !mem_we, "R10", "strobes",
            {done, mem_rd, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_rd && !mem_we && carry == 1'b0, "R10", "after release",
            {done, mem_rd, mem_we, carry}, 0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            run_op(VECS[k].op, VECS[k].addr, lat);
            chk(lat == int'(VECS[k].lat), "R8", $sformatf("latency v%0d", k),
                lat, VECS[k].lat);
            chk(carry == VECS[k].c, req_of(VECS[k].op, VECS[k].addr),
                $sformatf("carry v%0d", k), carry, VECS[k].c);
            chk(test_hit == VECS[k].hit, "R6", $sformatf("hit v%0d", k),
                test_hit, VECS[k].hit);
            @(negedge clk);
            chk(mem[VECS[k].baddr] == VECS[k].bval,
                VECS[k].addr[7] ? "R2" : "R1",
                $sformatf("byte %0h v%0d", VECS[k].baddr, k),
                mem[VECS[k].baddr], VECS[k].bval);
        end

        // R9: a second start during a busy operation is dropped
        @(negedge clk);
        start = 1'b1; op = 4'd7; bit_addr = 8'h05;
        @(negedge clk);
        op = 4'd6; bit_addr = 8'h00;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        repeat (12) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk(seen == 1, "R9", "done count", seen, 1);
        chk(mem[8'h20] == 8'h21, "R9", "byte 20", mem[8'h20], 8'h21);

        // R10: reset mid-life returns carry to zero
        chk(carry == 1'b1, "R10", "carry before reset", carry, 1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(carry == 1'b0 && !done, "R10", "carry after reset", carry, 0);
        rst_n = 1'b1;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule